// File: doc/BRIEF.md
# Power stage fault supervisor

This block is the protection and fault-reporting logic of a half-bridge power stage. It reads digital comparator results for high-side overcurrent, switch-node short and over-temperature, along with the two supply power-on flags, the present gate states and the decoded PWM command. From these it produces four outputs: a high-side gate inhibit, a force for the current-monitor output, a force for the temperature-monitor output, and an active-low fault line.

There are three kinds of fault. An overcurrent on the high side is recoverable. The inhibit and the flags stay set until the controller acknowledges by holding the PWM command at mid-level for a fixed clear delay. A short across the high-side switch, seen while the low side conducts, is latched, and only a drop of the logic supply clears it. Over-temperature is a hysteretic flag that is set and cleared by two comparators. It only raises the temperature force and the fault line. The fault line is also held low while either supply is down, and after both supplies come up it stays low for a fixed power-on delay.

None of the faults touches the low-side gate. The gate driver keeps following PWM low and mid-level commands.

Top module: `pstage_fault_sup`

## Requirements
- R1: If `oc_cmp` is high while `hs_gate_on`, `vin_ok` and `vcc_ok` are all high at a clock edge, then from that edge on `hs_inhibit` and `imon_force` are 1 and `fault_n` is 0.
- R2: Once an overcurrent fault is set, it stays set (inhibit, current force and fault line) for as long as the PWM command is not mid-level, no matter how long that is. PWM codes: 2'b00 low, 2'b01 high, 2'b10 and 2'b11 mid-level.
- R3: An overcurrent fault clears at the clock edge that completes CLR_DLY_CYC consecutive cycles of mid-level PWM. Any non-mid cycle restarts this count.
- R4: While `vin_ok` is 0, `oc_cmp` sets no fault, and `hs_inhibit` and `imon_force` stay 0.
- R5: If `sw_short_cmp` and `ls_gate_on` are both high at a clock edge with `vcc_ok` high, a short fault is latched. `hs_inhibit` and `imon_force` go to 1 and `fault_n` goes to 0. `sw_short_cmp` with `ls_gate_on` low has no effect.
- R6: A latched short fault survives every PWM code, including mid-level held beyond the overcurrent clear delay. It is cleared only by `vcc_ok` going low.
- R7: `ot_hi_cmp` sets an over-temperature flag, and `ot_lo_cmp` clears it. Between the two thresholds the flag holds its value. While the flag is set, `tmon_force` is 1 and `fault_n` is 0, with `hs_inhibit` and `imon_force` unchanged at 0.
- R8: `fault_n` is 0 whenever `vcc_ok` or `vin_ok` is 0. Once both are 1 with no other fault, `fault_n` goes to 1 at exactly the POR_DLY_CYC-th clock edge.
- R9: `vcc_ok` low at a clock edge clears a pending overcurrent fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_ok | input | 1 | Logic supply above its power-on level |
| vin_ok | input | 1 | Input supply above its power-on level |
| hs_gate_on | input | 1 | High-side gate currently on |
| ls_gate_on | input | 1 | Low-side gate currently on |
| pwm_code | input | 2 | Decoded PWM: 00 low, 01 high, 1x mid-level |
| oc_cmp | input | 1 | High-side current above trip level |
| sw_short_cmp | input | 1 | Switch node above short threshold |
| ot_hi_cmp | input | 1 | Temperature above the set threshold |
| ot_lo_cmp | input | 1 | Temperature below the release threshold |
| hs_inhibit | output | 1 | Force high-side gate off |
| imon_force | output | 1 | Drive current monitor to its fault level |
| tmon_force | output | 1 | Drive temperature monitor to its fault level |
| fault_n | output | 1 | Active-low fault report |

## Verification
Two events can land on the same edge. The overcurrent clear delay can expire at the very edge where a switch-node short is detected. The bench provokes this by holding mid-level PWM for one cycle less than the clear delay, then raising the short comparator and the low-side gate state so both take effect on the final edge. It then expects the inhibit, the current force and the fault line to stay asserted. They must still be asserted through a long mid-level dwell afterwards, and they may release only after a logic-supply drop and a full power-on delay.

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup #(
  parameter int CLR_DLY_CYC = 50,
  parameter int POR_DLY_CYC = 6250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_ok,
  input  logic       vin_ok,
  input  logic       hs_gate_on,
  input  logic       ls_gate_on,
  input  logic [1:0] pwm_code,
  input  logic       oc_cmp,
  input  logic       sw_short_cmp,
  input  logic       ot_hi_cmp,
  input  logic       ot_lo_cmp,
  output logic       hs_inhibit,
  output logic       imon_force,
  output logic       tmon_force,
  output logic       fault_n
);

  localparam int CLR_W = $clog2(CLR_DLY_CYC + 1);
  localparam int POR_W = $clog2(POR_DLY_CYC + 1);
  localparam logic [CLR_W-1:0] CLR_LAST = CLR_W'(CLR_DLY_CYC - 1);
  localparam logic [POR_W-1:0] POR_DONE = POR_W'(POR_DLY_CYC);

  logic             oc_q, short_q, ot_q;
  logic [CLR_W-1:0] clr_cnt;
  logic [POR_W-1:0] por_cnt;
  logic             pwm_mid, oc_hit, short_hit, por_ready, supplies_ok;

  assign pwm_mid     = (pwm_code == 2'b10) || (pwm_code == 2'b11);
  assign supplies_ok = vcc_ok && vin_ok;
  assign oc_hit      = oc_cmp && hs_gate_on && vin_ok && vcc_ok;
  assign short_hit   = sw_short_cmp && ls_gate_on && vcc_ok;
  assign por_ready   = (por_cnt == POR_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q    <= 1'b0;
      clr_cnt <= '0;
    end else if (!vcc_ok) begin
      oc_q    <= 1'b0;
      clr_cnt <= '0;
    end else if (oc_hit) begin
      oc_q    <= 1'b1;
      clr_cnt <= '0;
    end else if (oc_q && pwm_mid) begin
      if (clr_cnt == CLR_LAST) begin
        oc_q    <= 1'b0;
        clr_cnt <= '0;
      end else begin
        clr_cnt <= clr_cnt + 1'b1;
      end
    end else begin
      clr_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         short_q <= 1'b0;
    else if (!vcc_ok)   short_q <= 1'b0;
    else if (short_hit) short_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ot_q <= 1'b0;
    else if (ot_hi_cmp) ot_q <= 1'b1;
    else if (ot_lo_cmp) ot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            por_cnt <= '0;
    else if (!supplies_ok) por_cnt <= '0;
    else if (!por_ready)   por_cnt <= por_cnt + 1'b1;
  end

  assign hs_inhibit = oc_q || short_q;
  assign imon_force = oc_q || short_q;
  assign tmon_force = ot_q;
  assign fault_n    = !(oc_q || short_q || ot_q || !supplies_ok || !por_ready);

  AST_OC_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    oc_hit |=> (hs_inhibit && !fault_n)); // R1

  AST_OC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q && !pwm_mid && vcc_ok) |=> oc_q); // R2

  AST_OC_NO_EARLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_q && vcc_ok && clr_cnt != CLR_LAST) |=> oc_q); // R3

  AST_VIN_NO_OC: assert property (@(posedge clk) disable iff (!rst_n)
    (!vin_ok && !oc_q) |=> !oc_q); // R4

  AST_SHORT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (short_q && vcc_ok) |=> short_q); // R6

  AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && !ot_lo_cmp) |=> ot_q); // R7

  AST_SUPPLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !supplies_ok |-> !fault_n); // R8

  AST_VCC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> (!oc_q && !short_q)); // R9

endmodule

// File: tb/test_pstage_fault_sup.sv
module test_pstage_fault_sup;
  localparam int CLR = 50;
  localparam int POR = 6250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_ok = 1'b0, vin_ok = 1'b0, hs_gate_on = 1'b0, ls_gate_on = 1'b0;
  logic [1:0] pwm_code = 2'b00;
  logic oc_cmp = 1'b0, sw_short_cmp = 1'b0, ot_hi_cmp = 1'b0, ot_lo_cmp = 1'b0;
  logic hs_inhibit, imon_force, tmon_force, fault_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pstage_fault_sup #(.CLR_DLY_CYC(CLR), .POR_DLY_CYC(POR)) i_pstage_fault_sup (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vin_ok(vin_ok),
    .hs_gate_on(hs_gate_on), .ls_gate_on(ls_gate_on), .pwm_code(pwm_code),
    .oc_cmp(oc_cmp), .sw_short_cmp(sw_short_cmp), .ot_hi_cmp(ot_hi_cmp),
    .ot_lo_cmp(ot_lo_cmp), .hs_inhibit(hs_inhibit), .imon_force(imon_force),
    .tmon_force(tmon_force), .fault_n(fault_n));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input logic inh, input logic im, input logic tm, input logic fn);
    chk(req, "hs_inhibit", hs_inhibit, inh);
    chk(req, "imon_force", imon_force, im);
    chk(req, "tmon_force", tmon_force, tm);
    chk(req, "fault_n", fault_n, fn);
  endtask

  task automatic power_up(input string req);
    vcc_ok = 1'b1; vin_ok = 1'b1;
    tick(POR - 1);
    chk(req, "fault_n one edge before delay", fault_n, 1'b0);
    tick(1);
    chk(req, "fault_n at delay", fault_n, 1'b1);
  endtask

  task automatic make_oc();
    hs_gate_on = 1'b1; pwm_code = 2'b01; oc_cmp = 1'b1;
    tick(1);
    oc_cmp = 1'b0; hs_gate_on = 1'b0;
  endtask

  task automatic t_reset_and_por();
    chk_outs("R8", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(3);
    chk("R8", "fault_n supplies down", fault_n, 1'b0);
    power_up("R8");
  endtask

  task automatic t_overcurrent();
    make_oc();
    chk_outs("R1", 1'b1, 1'b1, 1'b0, 1'b0);
    tick(200);
    chk_outs("R2", 1'b1, 1'b1, 1'b0, 1'b0);
    pwm_code = 2'b00; ls_gate_on = 1'b1;
    tick(5);
    chk_outs("R2", 1'b1, 1'b1, 1'b0, 1'b0);
    ls_gate_on = 1'b0;
    pwm_code = 2'b10;
    tick(20);
    pwm_code = 2'b00;
    tick(1);
    pwm_code = 2'b11;
    tick(CLR - 1);
    chk_outs("R3", 1'b1, 1'b1, 1'b0, 1'b0);
    tick(1);
    chk_outs("R3", 1'b0, 1'b0, 1'b0, 1'b1);
    pwm_code = 2'b00;
  endtask

  task automatic t_vin_low();
    vin_ok = 1'b0;
    tick(1);
    chk("R8", "fault_n vin down", fault_n, 1'b0);
    hs_gate_on = 1'b1; pwm_code = 2'b01; oc_cmp = 1'b1;
    tick(3);
    chk("R4", "hs_inhibit vin down", hs_inhibit, 1'b0);
    chk("R4", "imon_force vin down", imon_force, 1'b0);
    oc_cmp = 1'b0; hs_gate_on = 1'b0; pwm_code = 2'b00;
    power_up("R8");
    chk("R4", "no latent oc", hs_inhibit, 1'b0);
  endtask

  task automatic t_overtemp();
    ot_hi_cmp = 1'b1;
    tick(1);
    chk_outs("R7", 1'b0, 1'b0, 1'b1, 1'b0);
    ot_hi_cmp = 1'b0;
    tick(10);
    chk_outs("R7", 1'b0, 1'b0, 1'b1, 1'b0);
    ot_lo_cmp = 1'b1;
    tick(1);
    chk_outs("R7", 1'b0, 1'b0, 1'b0, 1'b1);
    ot_lo_cmp = 1'b0;
  endtask

  task automatic t_vcc_clears_oc();
    make_oc();
    chk("R1", "oc set", imon_force, 1'b1);
    pwm_code = 2'b00;
    vcc_ok = 1'b0;
    tick(1);
    chk("R9", "imon_force after vcc drop", imon_force, 1'b0);
    chk("R9", "hs_inhibit after vcc drop", hs_inhibit, 1'b0);
    chk("R8", "fault_n vcc down", fault_n, 1'b0);
    power_up("R9");
  endtask

  task automatic t_short_overlap();
    sw_short_cmp = 1'b1;
    tick(2);
    chk("R5", "short ignored with ls off", imon_force, 1'b0);
    sw_short_cmp = 1'b0;
    make_oc();
    pwm_code = 2'b10;
    tick(CLR - 1);
    ls_gate_on = 1'b1; sw_short_cmp = 1'b1;
    tick(1);
    chk_outs("R5", 1'b1, 1'b1, 1'b0, 1'b0);
    ls_gate_on = 1'b0; sw_short_cmp = 1'b0;
    tick(3 * CLR);
    chk_outs("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    pwm_code = 2'b00;
    tick(5);
    chk_outs("R6", 1'b1, 1'b1, 1'b0, 1'b0);
    vcc_ok = 1'b0;
    tick(1);
    chk("R6", "fault_n vcc down", fault_n, 1'b0);
    power_up("R6");
    chk_outs("R6", 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    tick(2);
    t_reset_and_por();
    t_overcurrent();
    t_vin_low();
    t_overtemp();
    t_vcc_clears_oc();
    t_short_overlap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule